// File: doc/BRIEF.md
# LCD Backplane Phasing and Test-Mode Generator

This block produces the logic-level drive for a static liquid-crystal panel of 38 segments. A free-running oscillator clock is divided by 256 to form a square backplane wave of 50% duty. Each segment output carries either the same level as the backplane or its inverse. In phase means the segment is dark (off). In antiphase means the segment shows (on). The high-voltage translators outside the block then turn those levels into panel voltages. The oscillator may be an on-chip RC circuit or a clock supplied from outside the chip. The divider treats both the same way.

The on/off pattern comes from the latched display word or from a test mode chosen by a two-bit mode input. The test modes are all off, all on, and an alternating pattern across the segments. The mode and data inputs are registered on every oscillator cycle. The resulting pattern is loaded only when the backplane changes level, so the segment and backplane levels always move together on one edge.

The supply-good input works as an asynchronous clear. While it is low, the backplane and every segment are held low, so the panel sees no voltage, and the divider is held at zero.

The controller is a four-state machine:
- BLANK is the state while the supply is bad, and the state just after it returns.
- ARM lasts one cycle and lets the sampled inputs settle.
- LOW is the low half-period of the backplane.
- HIGH is the high half-period of the backplane.

The transitions are:
- BLANK goes to ARM on the first edge with the supply good.
- ARM goes to LOW on the next edge, loading the pattern.
- LOW goes to HIGH when the divider reaches 127.
- HIGH goes to LOW when the divider reaches 255.
- Any state returns to BLANK at once when the supply drops.

Top module: `lcd_phase_gen`

## Requirements
- R1: In each running period, the backplane is low for exactly 128 oscillator cycles and then high for exactly 128 cycles.
- R2: With mode_sel = 2'b00, segment i is on (the inverse of bp_o) when seg_data[i] is 1, and off (equal to bp_o) when seg_data[i] is 0.
- R3: With mode_sel = 2'b01, every segment is off (equal to bp_o), whatever seg_data holds.
- R4: With mode_sel = 2'b10, every segment is on (the inverse of bp_o), whatever seg_data holds.
- R5: With mode_sel = 2'b11, segments at even bit indices (segment numbers 1, 3, 5, …) are on and those at odd indices are off, whatever seg_data holds.
- R6: While supply_ok is low, bp_o and all of seg_o are low without waiting for a clock edge, and they stay low for as long as supply_ok stays low.
- R7: After supply_ok rises, the outputs stay low for the first edge (ARM). The second edge enters the low backplane half with the divider at zero and the pattern applied. The backplane rises 128 edges after that.
- R8: mode_sel and seg_data are registered on each oscillator edge. A change made inside a half-period alters no output until the next backplane edge, and seg_o changes only on a backplane edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, from the internal RC circuit or an external source |
| supply_ok | input | 1 | Logic supply good; low blanks the display and clears the block |
| mode_sel | input | 2 | Display mode: 00 data, 01 all off, 10 all on, 11 alternating |
| seg_data | input | 38 | Latched display word; bit i drives segment i+1 |
| bp_o | output | 1 | Backplane level |
| seg_o | output | 38 | Segment levels, one per segment |

## Verification
A divider that miscounts shows up at bp_o as a half-period that is not 128 cycles long. That is visible by the first backplane edge after the error, at most 128 cycles later. A pattern register that is loaded at the wrong time, or from the wrong mode, shows up as seg_o changing in the middle of a half-period, or as a wrong polarity at the next backplane edge. A state machine that leaves BLANK or ARM at the wrong time shifts the first backplane rise away from 130 edges after supply_ok returns.

// File: rtl/lcd_phase_pkg.sv
`timescale 1ns/1ps
package lcd_phase_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_ARM   = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } bp_state_t;

    typedef enum logic [1:0] {
        MODE_DATA = 2'b00,
        MODE_OFF  = 2'b01,
        MODE_ON   = 2'b10,
        MODE_ALT  = 2'b11
    } disp_mode_t;

endpackage

// File: rtl/lcd_input_sampler.sv
`timescale 1ns/1ps
module lcd_input_sampler
    import lcd_phase_pkg::*;
#(
    parameter int NSEG = 38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic [NSEG-1:0] data_i,
    output disp_mode_t      mode_o,
    output logic [NSEG-1:0] data_o
);

    // Register mode and data once per oscillator cycle (R8).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= MODE_DATA;
            data_o <= '0;
        end else begin
            mode_o <= disp_mode_t'(mode_i);
            data_o <= data_i;
        end
    end

endmodule

// File: rtl/lcd_pattern_sel.sv
`timescale 1ns/1ps
module lcd_pattern_sel
    import lcd_phase_pkg::*;
#(
    parameter int NSEG = 38
) (
    input  disp_mode_t      mode_i,
    input  logic [NSEG-1:0] data_i,
    output logic [NSEG-1:0] on_o
);

    // One selector per segment: a 1 means the segment is shown (antiphase).
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam bit ALT_ON = ((i % 2) == 0);   // R5: segment numbers 1,3,5,...
        always_comb begin
            unique case (mode_i)
                MODE_DATA: on_o[i] = data_i[i];   // R2
                MODE_OFF:  on_o[i] = 1'b0;        // R3
                MODE_ON:   on_o[i] = 1'b1;        // R4
                MODE_ALT:  on_o[i] = ALT_ON;      // R5
                default:   on_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lcd_bp_divider.sv
`timescale 1ns/1ps
module lcd_bp_divider #(
    parameter int DIV_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    output logic [DIV_BITS-1:0] cnt_o,
    output logic                mid_o,
    output logic                end_o
);

    localparam logic [DIV_BITS-1:0] MID_VAL = {1'b0, {(DIV_BITS-1){1'b1}}};
    localparam logic [DIV_BITS-1:0] END_VAL = {DIV_BITS{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (en_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assign mid_o = en_i && (cnt_o == MID_VAL);
    assign end_o = en_i && (cnt_o == END_VAL);

endmodule

// File: rtl/lcd_phase_gen.sv
`timescale 1ns/1ps
module lcd_phase_gen
    import lcd_phase_pkg::*;
#(
    parameter int NSEG     = 38,
    parameter int DIV_BITS = 8
) (
    input  logic            osc_clk,
    input  logic            supply_ok,
    input  logic [1:0]      mode_sel,
    input  logic [NSEG-1:0] seg_data,
    output logic            bp_o,
    output logic [NSEG-1:0] seg_o
);

    bp_state_t           state_q, state_d;
    disp_mode_t          mode_q;
    logic [NSEG-1:0]     data_q;
    logic [NSEG-1:0]     on_vec;
    logic [NSEG-1:0]     pat_q;
    logic [DIV_BITS-1:0] cnt_q;
    logic                div_mid, div_end;
    logic                running;
    logic                enter_phase;
    logic                bp_next;

    lcd_input_sampler #(.NSEG(NSEG)) u_samp (
        .clk    (osc_clk),
        .rst_n  (supply_ok),
        .mode_i (mode_sel),
        .data_i (seg_data),
        .mode_o (mode_q),
        .data_o (data_q)
    );

    lcd_pattern_sel #(.NSEG(NSEG)) u_pat (
        .mode_i (mode_q),
        .data_i (data_q),
        .on_o   (on_vec)
    );

    assign running = (state_q == ST_LOW) || (state_q == ST_HIGH);

    lcd_bp_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk   (osc_clk),
        .rst_n (supply_ok),
        .en_i  (running),
        .cnt_o (cnt_q),
        .mid_o (div_mid),
        .end_o (div_end)
    );

    // State register
    always_ff @(posedge osc_clk or negedge supply_ok) begin
        if (!supply_ok) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: state_d = ST_ARM;
            ST_ARM:   state_d = ST_LOW;
            ST_LOW:   state_d = div_mid ? ST_HIGH : ST_LOW;
            ST_HIGH:  state_d = div_end ? ST_LOW  : ST_HIGH;
            default:  state_d = ST_BLANK;
        endcase
    end

    assign enter_phase = (state_d != state_q) &&
                         ((state_d == ST_LOW) || (state_d == ST_HIGH));
    assign bp_next     = (state_d == ST_HIGH);

    // Outputs: backplane, pattern and segments all move on one edge.
    always_ff @(posedge osc_clk or negedge supply_ok) begin
        if (!supply_ok) begin
            bp_o  <= 1'b0;
            seg_o <= '0;
            pat_q <= '0;
        end else if (enter_phase) begin
            bp_o  <= bp_next;
            pat_q <= on_vec;
            seg_o <= on_vec ^ {NSEG{bp_next}};
        end
    end

endmodule

// File: rtl/lcd_phase_chk.sv
`timescale 1ns/1ps
module lcd_phase_chk
    import lcd_phase_pkg::*;
#(
    parameter int NSEG     = 38,
    parameter int DIV_BITS = 8
) (
    input  logic                osc_clk,
    input  logic                supply_ok,
    input  logic                bp_o,
    input  logic [NSEG-1:0]     seg_o,
    input  logic [NSEG-1:0]     pat_q,
    input  bp_state_t           state_q,
    input  logic [DIV_BITS-1:0] cnt_q
);

    logic running;
    assign running = (state_q == ST_LOW) || (state_q == ST_HIGH);

    a_r1_bp_tracks_divider: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        running |-> (bp_o == cnt_q[DIV_BITS-1]));

    a_r2_seg_phase: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        running |-> (seg_o == (pat_q ^ {NSEG{bp_o}})));

    a_r6_blank_low: assert property (@(posedge osc_clk)
        !supply_ok |-> (!bp_o && (seg_o == '0)));

    a_r7_arm_blank: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        (state_q == ST_ARM) |-> (!bp_o && (seg_o == '0)));

    a_r7_arm_to_low: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        (state_q == ST_ARM) |=> ((state_q == ST_LOW) && (cnt_q == '0)));

    a_r8_hold_in_phase: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        (running && (cnt_q[DIV_BITS-2:0] != '0)) |-> ($stable(seg_o) && $stable(bp_o) && $stable(pat_q)));

endmodule

bind lcd_phase_gen lcd_phase_chk #(.NSEG(NSEG), .DIV_BITS(DIV_BITS)) u_chk (
    .osc_clk   (osc_clk),
    .supply_ok (supply_ok),
    .bp_o      (bp_o),
    .seg_o     (seg_o),
    .pat_q     (pat_q),
    .state_q   (state_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_lcd_phase_gen.sv
`timescale 1ns/1ps
module sim_lcd_phase_gen;

    localparam int NSEG = 38;
    localparam int NVEC = 8;
    localparam logic [NSEG-1:0] ALL1 = '1;
    localparam logic [NSEG-1:0] ALT  = 38'h1555555555;

    localparam logic [1:0] VMODE [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                            2'b00, 2'b00, 2'b11, 2'b00};
    localparam logic [NSEG-1:0] VDATA [NVEC] = '{38'h123456789A, 38'h3FFFFFFFFF, 38'h0, 38'h2AAAAAAAAA,
                                                 38'h3FFFFFFFFF, 38'h0, 38'h0, 38'h2AAAAAAAAA};
    localparam logic [NSEG-1:0] VEXP [NVEC] = '{38'h123456789A, 38'h0, 38'h3FFFFFFFFF, 38'h1555555555,
                                                38'h3FFFFFFFFF, 38'h0, 38'h1555555555, 38'h2AAAAAAAAA};

    logic            clk = 1'b0;
    logic            supply_ok;
    logic [1:0]      mode_sel;
    logic [NSEG-1:0] seg_data;
    logic            bp_o;
    logic [NSEG-1:0] seg_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic            exp_bp;
    logic [NSEG-1:0] prev_exp;

    always #2.5 clk = ~clk;

    lcd_phase_gen u0 (
        .osc_clk   (clk),
        .supply_ok (supply_ok),
        .mode_sel  (mode_sel),
        .seg_data  (seg_data),
        .bp_o      (bp_o),
        .seg_o     (seg_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [NSEG-1:0] act, input logic [NSEG-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #1000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        supply_ok = 1'b1;
        mode_sel  = 2'b11;
        seg_data  = '0;
        #1 supply_ok = 1'b0;
        step(1);
        check("R6 reset bp", {37'b0, bp_o}, '0);
        check("R6 reset seg", seg_o, '0);
        step(3);
        check("R6 held seg", seg_o, '0);

        // R7 restart timing, R5 alternating pattern at entry
        supply_ok = 1'b1;
        step(1);
        check("R7 arm seg", seg_o, '0);
        check("R7 arm bp", {37'b0, bp_o}, '0);
        step(1);
        check("R5 entry seg", seg_o, ALT);
        step(127);
        check("R1 still low", {37'b0, bp_o}, '0);
        step(1);
        check("R1 rise", {37'b0, bp_o}, 38'd1);
        check("R5 high seg", seg_o, ~ALT);
        exp_bp   = 1'b1;
        prev_exp = ALT;

        // Vector table, one half-period per entry
        for (int i = 0; i < NVEC; i++) begin
            mode_sel = VMODE[i];
            seg_data = VDATA[i];
            step(127);
            check("R8 hold seg", seg_o, prev_exp ^ {NSEG{exp_bp}});
            check("R1 hold bp", {37'b0, bp_o}, {37'b0, exp_bp});
            step(1);
            exp_bp = ~exp_bp;
            check("R1 toggle", {37'b0, bp_o}, {37'b0, exp_bp});
            check(tag_of(VMODE[i]), seg_o, VEXP[i] ^ {NSEG{exp_bp}});
            prev_exp = VEXP[i];
        end

        // Blanking mid-phase and restart
        step(40);
        supply_ok = 1'b0;
        #1;
        check("R6 async bp", {37'b0, bp_o}, '0);
        check("R6 async seg", seg_o, '0);
        mode_sel = 2'b10;
        seg_data = '1;
        step(4);
        check("R6 stays seg", seg_o, '0);
        supply_ok = 1'b1;
        step(1);
        check("R7 arm again", seg_o, '0);
        step(1);
        check("R7 R4 entry seg", seg_o, ALL1);
        step(127);
        check("R7 counter cleared", {37'b0, bp_o}, '0);
        step(1);
        check("R7 rise", {37'b0, bp_o}, 38'd1);
        check("R4 high seg", seg_o, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule